// File: doc/BRIEF.md
# I2C SCL Clock Generator

This block produces the serial-clock timing for an I2C controller. It divides the peripheral clock by a programmable pre-divider to form an internal tick. It then counts out each SCL period in internal ticks. One period is 20 ticks, plus 8 ticks per step of a gap field, plus a separately programmed compensation count. The compensation count covers line rise and fall times and internal delay.

The block drives SCL low during the first half of each period and releases it for the second half. At each phase boundary it emits a one-cycle strobe for the bit engine. It also emits a sample strobe in the middle of the high phase. While SCL is released but another device still holds it low, the high-phase count pauses, so clock stretching lengthens the period.

A single configuration word carries both fields. The pre-divider field sits in the low bits, and its width is a parameter (2 or 3 bits). The 6-bit gap field sits directly above it. The driver software that picks these values is outside this block.

Top module: `i2c_scl_timer`

## Requirements
- R1: Under reset, `ick_en`, `scl_drive_low`, `low_start`, `high_start` and `sample_pt` are all 0.
- R2: While `en` is 0, no `ick_en` pulse and no strobe occur, and SCL is released. The pre-divider field is captured only while `en` is 0. Changing it while enabled has no effect until the next enable.
- R3: While enabled, `ick_en` is a one-cycle pulse every D = 1 + CDF clocks. CDF is `clk_cfg[CDF_W-1:0]`.
- R4: The gap field SCGD is `clk_cfg[CDF_W +: 6]`, with values 0 to 63, including the maximum.
- R5: Consecutive `low_start` pulses are P = 20 + 8·SCGD + `comp_cnt` ticks apart, that is P·D clocks, when SCL is not stretched.
- R6: The low phase lasts L = floor(P/2) ticks, from `low_start` to `high_start`. `scl_drive_low` is 1 throughout it.
- R7: The high phase lasts H = P − L ticks, from `high_start` to the next `low_start`. `scl_drive_low` is 0 throughout it.
- R8: `sample_pt` pulses floor(H/2) ticks after `high_start`, during the high phase.
- R9: During the high phase, a tick advances the count only while `scl_in` reads 1. While another device holds SCL low, no `sample_pt` and no `low_start` occur. Once SCL reads high, `sample_pt` and `low_start` follow floor(H/2) and H ticks later.
- R10: The first tick after enable starts a low phase. SCGD and `comp_cnt` are sampled at each `low_start`, so a change during a period takes effect from the next period.
- R11: At most one of `low_start`, `high_start` and `sample_pt` is high in any cycle, and each lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; 0 idles the generator and releases SCL |
| clk_cfg | input | CDF_W+6 | Configuration word: {SCGD, CDF} |
| comp_cnt | input | COMP_W | Rise/fall/delay compensation in ticks |
| scl_in | input | 1 | Sensed SCL line level (already synchronised) |
| ick_en | output | 1 | Internal-clock tick enable |
| scl_drive_low | output | 1 | 1 pulls SCL low (open drain) |
| low_start | output | 1 | Strobe: low phase begins |
| high_start | output | 1 | Strobe: high phase begins |
| sample_pt | output | 1 | Strobe: data sample point in high phase |

## Verification
Every strobe is registered one tick after its boundary is reached. The first `low_start` therefore appears D+1 clocks after `en` rises. Other boundary intervals are multiples of D: L·D from `low_start` to `high_start`, floor(H/2)·D from there to `sample_pt`, and H·D from there to the next `low_start`. The monitor samples at falling edges and stamps each strobe with a cycle number. It compares every interval against a queue of expected values pushed by the driver before enabling, so no result depends on when a check is made. For stretching, the driver releases the line at a falling edge and expects `sample_pt` 5 edges later and `low_start` 10 edges later, at CDF=0.

// File: rtl/i2c_scl_timer_pkg.sv
// Shared constants and types for the SCL clock generator.
package i2c_scl_timer_pkg;
    // Fixed part of the SCL period, in internal ticks
    localparam int unsigned BASE_TICKS = 20;
    // Each gap step adds 2**GAP_SHIFT ticks
    localparam int unsigned GAP_SHIFT  = 3;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;
endpackage

// File: rtl/scl_prediv.sv
// Pre-divider: produces a one-cycle tick every (1 + div) clocks.
// Assumes: the divide value is captured only while run is low, so a
// change while running cannot shorten or lengthen a tick interval.
module scl_prediv #(
    parameter int unsigned DIV_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_in,
    output logic             tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] cnt_q;

    // Count 0..div_q and pulse tick on wrap; capture divide while idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (!run) begin
            div_q <= div_in;
            cnt_q <= '0;
            tick  <= 1'b0;
        end else if (cnt_q == div_q) begin
            cnt_q <= '0;
            tick  <= 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            tick  <= 1'b0;
        end
    end
endmodule

// File: rtl/scl_phase_len.sv
// Phase length unit: derives low, high and sample-point tick counts
// from the gap field and compensation count (purely combinational).
// Assumes: CNT_W is wide enough for the largest period.
module scl_phase_len
    import i2c_scl_timer_pkg::*;
#(
    parameter int unsigned GAP_W  = 6,
    parameter int unsigned COMP_W = 6,
    parameter int unsigned CNT_W  = 10
) (
    input  logic [GAP_W-1:0]  gap,
    input  logic [COMP_W-1:0] comp,
    output logic [CNT_W-1:0]  low_len,
    output logic [CNT_W-1:0]  high_len,
    output logic [CNT_W-1:0]  smp_len
);
    logic [CNT_W-1:0] period;

    // Period split: low takes the floor half, high the rest, sample mid-high
    always_comb begin
        period   = CNT_W'(BASE_TICKS) + (CNT_W'(gap) << GAP_SHIFT) + CNT_W'(comp);
        low_len  = period >> 1;
        high_len = period - low_len;
        smp_len  = high_len >> 1;
    end
endmodule

// File: rtl/scl_phase_fsm.sv
// Phase sequencer: walks IDLE -> LOW -> HIGH -> LOW ... on ticks,
// emits registered strobes, and pauses the high count while SCL is
// held low externally (clock stretching).
// Assumes: scl_in is already synchronised to clk; lengths are >= 2.
module scl_phase_fsm
    import i2c_scl_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             scl_in,
    input  logic [CNT_W-1:0] low_len,
    input  logic [CNT_W-1:0] high_len,
    input  logic [CNT_W-1:0] smp_len,
    output logic             drive_low,
    output logic             in_high,
    output logic             low_start,
    output logic             high_start,
    output logic             sample
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    phase_e           ph_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lo_q;
    logic [CNT_W-1:0] hi_q;
    logic [CNT_W-1:0] sp_q;

    // Sequence phases, latch lengths on each low entry, pulse strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q       <= PH_IDLE;
            cnt_q      <= '0;
            lo_q       <= '0;
            hi_q       <= '0;
            sp_q       <= '0;
            low_start  <= 1'b0;
            high_start <= 1'b0;
            sample     <= 1'b0;
        end else begin
            low_start  <= 1'b0;
            high_start <= 1'b0;
            sample     <= 1'b0;
            if (!run) begin
                ph_q  <= PH_IDLE;
                cnt_q <= '0;
            end else if (tick) begin
                case (ph_q)
                    PH_IDLE: begin
                        ph_q      <= PH_LOW;
                        cnt_q     <= '0;
                        lo_q      <= low_len;
                        hi_q      <= high_len;
                        sp_q      <= smp_len;
                        low_start <= 1'b1;
                    end
                    PH_LOW: begin
                        if (cnt_q == lo_q - ONE) begin
                            ph_q       <= PH_HIGH;
                            cnt_q      <= '0;
                            high_start <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + ONE;
                        end
                    end
                    PH_HIGH: begin
                        if (scl_in) begin
                            if (cnt_q == sp_q - ONE) begin
                                sample <= 1'b1;
                            end
                            if (cnt_q == hi_q - ONE) begin
                                ph_q      <= PH_LOW;
                                cnt_q     <= '0;
                                lo_q      <= low_len;
                                hi_q      <= high_len;
                                sp_q      <= smp_len;
                                low_start <= 1'b1;
                            end else begin
                                cnt_q <= cnt_q + ONE;
                            end
                        end
                    end
                    default: begin
                        ph_q  <= PH_IDLE;
                        cnt_q <= '0;
                    end
                endcase
            end
        end
    end

    // Open-drain request and phase flag decoded from the state
    always_comb begin
        drive_low = (ph_q == PH_LOW);
        in_high   = (ph_q == PH_HIGH);
    end
endmodule

// File: rtl/i2c_scl_timer.sv
// SCL clock generator top: splits the configuration word, runs the
// pre-divider, phase length unit and phase sequencer.
// Assumes: clk_cfg = {gap, div}; scl_in is synchronised externally.
module i2c_scl_timer #(
    parameter int unsigned CDF_W  = 3,
    parameter int unsigned SCGD_W = 6,
    parameter int unsigned COMP_W = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic [CDF_W+SCGD_W-1:0] clk_cfg,
    input  logic [COMP_W-1:0]       comp_cnt,
    input  logic                    scl_in,
    output logic                    ick_en,
    output logic                    scl_drive_low,
    output logic                    low_start,
    output logic                    high_start,
    output logic                    sample_pt
);
    localparam int unsigned MAX_PERIOD = i2c_scl_timer_pkg::BASE_TICKS
        + ((2 ** SCGD_W - 1) << i2c_scl_timer_pkg::GAP_SHIFT) + (2 ** COMP_W - 1);
    localparam int unsigned CNT_W = $clog2(MAX_PERIOD + 1);

    logic [CDF_W-1:0]  div_fld;
    logic [SCGD_W-1:0] gap_fld;
    logic [CNT_W-1:0]  low_len;
    logic [CNT_W-1:0]  high_len;
    logic [CNT_W-1:0]  smp_len;
    logic              phase_high;

    // Field split of the configuration word
    always_comb begin
        div_fld = clk_cfg[CDF_W-1:0];
        gap_fld = clk_cfg[CDF_W +: SCGD_W];
    end

    scl_prediv #(.DIV_W(CDF_W)) u_prediv (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (en),
        .div_in (div_fld),
        .tick   (ick_en)
    );

    scl_phase_len #(.GAP_W(SCGD_W), .COMP_W(COMP_W), .CNT_W(CNT_W)) u_len (
        .gap      (gap_fld),
        .comp     (comp_cnt),
        .low_len  (low_len),
        .high_len (high_len),
        .smp_len  (smp_len)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (en),
        .tick       (ick_en),
        .scl_in     (scl_in),
        .low_len    (low_len),
        .high_len   (high_len),
        .smp_len    (smp_len),
        .drive_low  (scl_drive_low),
        .in_high    (phase_high),
        .low_start  (low_start),
        .high_start (high_start),
        .sample     (sample_pt)
    );
endmodule

// File: rtl/i2c_scl_timer_chk.sv
// Property checker for the SCL clock generator, bound to the top.
module i2c_scl_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic scl_in,
    input logic ick_en,
    input logic scl_drive_low,
    input logic low_start,
    input logic high_start,
    input logic sample_pt,
    input logic phase_high
);
    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !ick_en); // R2
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !scl_drive_low); // R2
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_start, high_start, sample_pt})); // R11
    AST_LOW_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        low_start |=> !low_start); // R11
    AST_LOW_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        low_start |-> scl_drive_low); // R6
    AST_HIGH_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        high_start |-> !scl_drive_low); // R7
    AST_SAMPLE_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sample_pt |-> (phase_high && !scl_drive_low)); // R8
    AST_STRETCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_high && !scl_in) |=> (!low_start && !sample_pt)); // R9
endmodule

bind i2c_scl_timer i2c_scl_timer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .en            (en),
    .scl_in        (scl_in),
    .ick_en        (ick_en),
    .scl_drive_low (scl_drive_low),
    .low_start     (low_start),
    .high_start    (high_start),
    .sample_pt     (sample_pt),
    .phase_high    (phase_high)
);

// File: tb/i2c_scl_timer_tb_top.sv
module i2c_scl_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [8:0] cfg = '0;
    logic [5:0] comp = '0;
    logic       ext_hold = 1'b0;
    logic       scl_line;
    logic       ick_en, drv, ls, hs, sp;

    assign scl_line = !drv && !ext_hold;

    always #2 clk = ~clk;

    i2c_scl_timer #(.CDF_W(3), .SCGD_W(6), .COMP_W(6)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .en            (en),
        .clk_cfg       (cfg),
        .comp_cnt      (comp),
        .scl_in        (scl_line),
        .ick_en        (ick_en),
        .scl_drive_low (drv),
        .low_start     (ls),
        .high_start    (hs),
        .sample_pt     (sp)
    );

    typedef struct {
        int    kind;   // 0 low len, 1 sample offset, 2 period, 3 high len
        int    val;
        string tag;
    } exp_t;

    exp_t q[$];
    int   n_tests = 0;
    int   n_fail = 0;
    bit   mon_on = 1'b0;
    bit   have_prev = 1'b0;
    int   cyc = 0;
    int   t_ls = 0;
    int   t_hs = 0;

    function automatic void chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endfunction

    function automatic void pop_cmp(input int kind, input int got);
        exp_t e;
        if (q.size() == 0) return;
        e = q.pop_front();
        chk(e.kind == kind && e.val == got, e.tag, got, e.val);
    endfunction

    // Monitor: time-stamp strobes and compare intervals against the queue
    always @(negedge clk) begin
        cyc++;
        if (!mon_on || !en) begin
            have_prev = 1'b0;
        end else begin
            if (ls) begin
                if (have_prev) begin
                    pop_cmp(2, cyc - t_ls);
                    pop_cmp(3, cyc - t_hs);
                end
                have_prev = 1'b1;
                t_ls = cyc;
            end
            if (hs && have_prev) begin
                pop_cmp(0, cyc - t_ls);
                t_hs = cyc;
            end
            if (sp && have_prev) pop_cmp(1, cyc - t_hs);
        end
    end

    task automatic push_period(input int d, input int p, input string ptag);
        int l, h;
        exp_t e;
        l = p / 2;
        h = p - l;
        e.kind = 0; e.val = l * d;       e.tag = "R6";  q.push_back(e);
        e.kind = 1; e.val = (h / 2) * d; e.tag = "R8";  q.push_back(e);
        e.kind = 2; e.val = p * d;       e.tag = ptag;  q.push_back(e);
        e.kind = 3; e.val = h * d;       e.tag = "R7";  q.push_back(e);
    endtask

    task automatic measure_tick(input int d, input string req);
        int n;
        do @(negedge clk); while (!ick_en);
        n = 0;
        do begin @(negedge clk); n++; end while (!ick_en);
        chk(n == d, req, n, d);
    endtask

    task automatic wait_empty();
        int w;
        w = 0;
        while (q.size() != 0 && w < 20000) begin @(negedge clk); w++; end
        if (q.size() != 0) begin
            chk(1'b0, "R5", q.size(), 0);
            q.delete();
        end
    endtask

    task automatic stop_run();
        @(negedge clk);
        en = 1'b0;
        mon_on = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // Driver: configure, queue expected intervals, enable, then drain
    task automatic run_cfg(input int cdf, input int scgd, input int r, input int nper, input string ptag);
        int d, p, n;
        d = cdf + 1;
        p = 20 + 8 * scgd + r;
        for (int i = 0; i < nper; i++) push_period(d, p, ptag);
        @(negedge clk);
        cfg = {6'(scgd), 3'(cdf)};
        comp = 6'(r);
        @(negedge clk);
        en = 1'b1;
        mon_on = 1'b1;
        n = 0;
        do begin @(negedge clk); n++; end while (!ls);
        chk(n == d + 1, "R10", n, d + 1);
        measure_tick(d, "R3");
        wait_empty();
        stop_run();
    endtask

    initial begin
        int n;
        bit bad;
        exp_t e;
        repeat (3) @(negedge clk);
        chk(!ick_en && !drv && !ls && !hs && !sp, "R1", {ick_en, drv, ls, hs, sp}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!ick_en && !drv && !ls && !hs && !sp, "R1", {ick_en, drv, ls, hs, sp}, 0);

        // R2: disabled generator stays quiet with SCL released
        bad = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (ick_en || drv || ls || hs || sp) bad = 1'b1;
        end
        chk(!bad, "R2", bad, 0);

        run_cfg(0, 0, 0, 3, "R5");
        run_cfg(1, 3, 5, 2, "R5");
        run_cfg(4, 10, 7, 2, "R5");
        run_cfg(7, 63, 63, 2, "R4");
        run_cfg(2, 0, 63, 2, "R5");

        // R10 / R2: mid-period change applies next period, CDF kept while enabled
        push_period(3, 28, "R10");
        push_period(3, 63, "R10");
        push_period(3, 63, "R10");
        @(negedge clk);
        cfg = {6'd1, 3'd2};
        comp = 6'd0;
        @(negedge clk);
        en = 1'b1;
        mon_on = 1'b1;
        do @(negedge clk); while (!ls);
        cfg = {6'd5, 3'd0};
        comp = 6'd3;
        measure_tick(3, "R2");
        wait_empty();
        stop_run();

        // R9: clock stretching at CDF=0, P=20 (L=10, H=10)
        @(negedge clk);
        cfg = '0;
        comp = '0;
        @(negedge clk);
        en = 1'b1;
        do @(negedge clk); while (!ls);
        chk(drv, "R6", drv, 1);
        ext_hold = 1'b1;
        do @(negedge clk); while (!hs);
        chk(!drv, "R7", drv, 0);
        bad = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (sp || ls || drv) bad = 1'b1;
        end
        chk(!bad, "R9", bad, 0);
        ext_hold = 1'b0;
        n = 0;
        do begin @(negedge clk); n++; end while (!sp && n < 100);
        chk(n == 5, "R9", n, 5);
        do begin @(negedge clk); n++; end while (!ls && n < 100);
        chk(n == 10, "R9", n, 10);
        stop_run();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 190000, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule